// File: doc/BRIEF.md
# One-time-programmable byte store with mode decoder and identifier readout

This block models the control side of a one-time-programmable byte memory. Four level inputs decide the operating mode:
- a chip select;
- an output enable;
- a program-level flag, which stands in for the high programming voltage;
- an identifier flag, which stands in for the high voltage on address bit 9.

The decoder turns them into one of six modes: standby, program inhibit, program, output off, array read (which also serves for program verify) and identifier readout.

The output is a byte bus together with a drive flag, which takes the place of a tri-state enable. While the drive flag is low, the bus reads zero. Storage starts blank, with every bit set to one. Program cycles can only clear bits, so a location can be programmed many times and each pass only removes ones.

Output data does not appear at once. It becomes valid a parameterised number of cycles after the most recent change of the address, the identifier flag or the read enable condition. A 64K×8 instance uses `ADDR_W = 16`. The default parameters keep the array small.

Top module: `otp_byte_store`

## Requirements
- R1: `dout_drive` is high only when `chip_sel` = 1, `out_en` = 1 and `prog_lvl` = 0; whenever `dout_drive` is low, `dout` reads 8'h00.
- R2: with `chip_sel` = 0 the block is in standby and `dout_drive` stays low whatever the value of `out_en`.
- R3: with `chip_sel` = 1 and `prog_lvl` = 1, every rising clock edge ANDs `din` into the byte at `addr`. A later array read of that address returns the stored result.
- R4: with `prog_lvl` = 1 and `chip_sel` = 0 (program inhibit), no byte changes, even when `din` is 8'h00.
- R5: after reset every byte reads 8'hFF, and programming never turns a stored zero back into a one.
- R6: in identifier readout (`id_hv` = 1 in a read), with `addr[1]` = 1, `addr[0]` = 0 returns 8'h1C and `addr[0]` = 1 returns 8'h83. Higher address bits are ignored.
- R7: in identifier readout with `addr[1]` = 0, the output is 8'h7F for both values of `addr[0]`.
- R8: every identifier byte has odd parity over its eight bits, with bit 7 acting as the parity bit.
- R9: `dout_drive` rises `LAT`+1 rising edges after the latest change of `addr`, `id_hv` or the read condition (R1). It is low at the edge before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restores a blank array |
| chip_sel | input | 1 | Device select, active high |
| out_en | input | 1 | Output gate, active high |
| prog_lvl | input | 1 | Programming level present |
| id_hv | input | 1 | High-voltage flag on address bit 9, selects identifier readout |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data, zero when not driven |
| dout_drive | output | 1 | Output driver enable, stands in for tri-state |

## Verification
The clocked properties assume the mode inputs and the address change only between clock edges and stay steady while a read settles. The bench drives every input at the falling edge and holds it for `LAT`+2 cycles before it samples.

The parity property on identifier bytes assumes the two low address bits are never unknown. The bench gives every address a defined value from time zero.

The programming sequences clear bits only through `din`. Each read is checked twice: once at the edge where the data must still be absent, and once where it must be present.

// File: rtl/otp_pkg.sv
package otp_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      M_STANDBY,
      M_INHIBIT,
      M_PROGRAM,
      M_OUT_OFF,
      M_READ,
      M_IDENT
   } op_mode_e;

   function automatic logic odd_parity(input logic [BYTE_W-1:0] b);
      return ^b;
   endfunction
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
   import otp_pkg::*;
(
   input  logic chip_sel,
   input  logic out_en,
   input  logic prog_lvl,
   input  logic id_hv,
   output logic wr_en,
   output logic drive_req,
   output logic id_sel
);
   op_mode_e mode;

   // Priority: select, then program level, then output gate, then identifier flag.
   always_comb begin
      if (!chip_sel)     mode = prog_lvl ? M_INHIBIT : M_STANDBY;
      else if (prog_lvl) mode = M_PROGRAM;
      else if (!out_en)  mode = M_OUT_OFF;
      else if (id_hv)    mode = M_IDENT;
      else               mode = M_READ;
   end

   assign wr_en     = (mode == M_PROGRAM);
   assign drive_req = (mode == M_READ) || (mode == M_IDENT);
   assign id_sel    = (mode == M_IDENT);
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
   import otp_pkg::*;
#(
   parameter int ADDR_W = 10,
   localparam int DEPTH = 1 << ADDR_W,
   localparam int STORE_W = DEPTH * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] rd_byte
);
   logic [STORE_W-1:0] store;

   // Each program edge can only clear bits of the addressed byte.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) store <= '1;
      else if (wr_en)
         store[int'(addr)*BYTE_W +: BYTE_W] <= store[int'(addr)*BYTE_W +: BYTE_W] & din;
   end

   assign rd_byte = store[int'(addr)*BYTE_W +: BYTE_W];

   p_inhibit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(store))
      else $error("store changed without a program cycle");

   p_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((store & ~$past(store)) == '0))
      else $error("a stored zero returned to one");
endmodule

// File: rtl/otp_ident_rom.sv
module otp_ident_rom
   import otp_pkg::*;
#(
   parameter logic [BYTE_W-1:0] MFR_CODE  = 8'h1C,
   parameter logic [BYTE_W-1:0] DEV_CODE  = 8'h83,
   parameter logic [BYTE_W-1:0] CONT_CODE = 8'h7F
) (
   input  logic [1:0]        sel,
   output logic [BYTE_W-1:0] id_byte
);
   if (^MFR_CODE != 1'b1)  begin : g_bad_mfr  $error("MFR_CODE lacks odd parity");  end
   if (^DEV_CODE != 1'b1)  begin : g_bad_dev  $error("DEV_CODE lacks odd parity");  end
   if (^CONT_CODE != 1'b1) begin : g_bad_cont $error("CONT_CODE lacks odd parity"); end

   always_comb begin
      if (sel[1]) id_byte = sel[0] ? DEV_CODE : MFR_CODE;
      else        id_byte = CONT_CODE;
   end

   always_comb begin
      if (!$isunknown(sel))
         p_ident_odd_r8: assert (odd_parity(id_byte))
            else $error("identifier byte without odd parity");
   end
endmodule

// File: rtl/otp_settle_timer.sv
module otp_settle_timer #(
   parameter int KEY_W = 12,
   parameter int LAT   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] key,
   input  logic             req,
   output logic             ok
);
   logic [KEY_W-1:0] prev_key;
   logic             chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_key <= '0;
      else        prev_key <= key;
   end

   assign chg = (key != prev_key);

   if (LAT == 0) begin : g_fast
      assign ok = req && !chg;
   end else begin : g_count
      localparam int CNT_W = $clog2(LAT + 1);
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LAT);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt <= '0;
         else if (chg || !req)  cnt <= '0;
         else if (cnt != LIMIT) cnt <= cnt + 1'b1;
      end

      assign ok = req && !chg && (cnt == LIMIT);
   end

   p_settle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> (key == $past(key)))
      else $error("data valid in the cycle its inputs changed");
endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
   import otp_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LAT    = 1,
   parameter logic [7:0] MFR_CODE  = 8'h1C,
   parameter logic [7:0] DEV_CODE  = 8'h83,
   parameter logic [7:0] CONT_CODE = 8'h7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_sel,
   input  logic              out_en,
   input  logic              prog_lvl,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              dout_drive
);
   localparam int KEY_W = ADDR_W + 2;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 2..16");
   end
   if (LAT < 0) begin : g_bad_lat
      $error("LAT must not be negative");
   end

   logic             wr_en, drive_req, id_sel, ready;
   logic [7:0]       arr_byte, id_byte;
   logic [KEY_W-1:0] key;

   otp_mode_decode u_dec (
      .chip_sel (chip_sel),
      .out_en   (out_en),
      .prog_lvl (prog_lvl),
      .id_hv    (id_hv),
      .wr_en    (wr_en),
      .drive_req(drive_req),
      .id_sel   (id_sel)
   );

   otp_cell_array #(.ADDR_W(ADDR_W)) u_cells (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .din    (din),
      .rd_byte(arr_byte)
   );

   otp_ident_rom #(
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE),
      .CONT_CODE(CONT_CODE)
   ) u_id (
      .sel    (addr[1:0]),
      .id_byte(id_byte)
   );

   assign key = {addr, id_hv, drive_req};

   otp_settle_timer #(.KEY_W(KEY_W), .LAT(LAT)) u_settle (
      .clk  (clk),
      .rst_n(rst_n),
      .key  (key),
      .req  (drive_req),
      .ok   (ready)
   );

   assign dout_drive = ready;
   assign dout       = !ready ? 8'h00 : (id_sel ? id_byte : arr_byte);

   p_drive_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dout_drive |-> (chip_sel && out_en && !prog_lvl))
      else $error("output driven outside a read");

   p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_drive |-> (dout == 8'h00))
      else $error("bus not zero while undriven");

   p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_sel |-> !dout_drive)
      else $error("output driven in standby");

   p_mfr_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_drive && id_hv && addr[1] && !addr[0]) |-> (dout == MFR_CODE))
      else $error("wrong manufacturer byte");

   p_cont_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_drive && id_hv && !addr[1]) |-> (dout == CONT_CODE))
      else $error("wrong continuation byte");
endmodule

// File: tb/sim_otp_byte_store.sv
module sim_otp_byte_store;
   localparam int AW  = 10;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chip_sel = 1'b0, out_en = 1'b0, prog_lvl = 1'b0, id_hv = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = 8'hFF;
   logic [7:0]    dout;
   logic          dout_drive;

   int  cyc = 0;
   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   typedef struct {
      int         due;
      logic       drv;
      logic [7:0] data;
      bit         par;
      string      req;
   } exp_t;

   exp_t       sb[$];
   logic [7:0] model [0:(1<<AW)-1];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   otp_byte_store #(.ADDR_W(AW), .LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .out_en(out_en),
      .prog_lvl(prog_lvl), .id_hv(id_hv), .addr(addr), .din(din),
      .dout(dout), .dout_drive(dout_drive)
   );

   // Monitor: compare queued expectations that fall due in this cycle.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (dout_drive !== e.drv || dout !== e.data) begin
               errors++;
               $display("FAIL %s: cycle %0d drive=%b dout=%h, expected drive=%b dout=%h",
                        e.req, cyc, dout_drive, dout, e.drv, e.data);
            end
            if (e.par) begin
               checks++;
               if (^dout !== 1'b1) begin
                  errors++;
                  $display("FAIL R8: parity of %h is %b, expected 1", dout, ^dout);
               end
            end
         end
      end
   end

   // Driver: apply a steady condition, expect nothing at LAT edges and the result at LAT+1.
   task automatic settle(input logic cs, input logic oe, input logic pl, input logic hv,
                         input logic [AW-1:0] a, input logic xdrv, input logic [7:0] xdata,
                         input bit par, input string req);
      chip_sel = cs; out_en = oe; prog_lvl = pl; id_hv = hv; addr = a;
      sb.push_back('{due: cyc + LAT, drv: 1'b0, data: 8'h00, par: 1'b0, req: "R9"});
      sb.push_back('{due: cyc + LAT + 1, drv: xdrv, data: xdata, par: par, req: req});
      repeat (LAT + 2) @(negedge clk);
   endtask

   task automatic read_arr(input logic [AW-1:0] a, input string req);
      settle(1, 1, 0, 0, a, 1'b1, model[a], 0, req);
   endtask

   task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
      chip_sel = 1; out_en = 0; prog_lvl = 1; id_hv = 0; addr = a; din = d;
      model[a] = model[a] & d;
      sb.push_back('{due: cyc, drv: 1'b0, data: 8'h00, par: 1'b0, req: "R1"});
      @(negedge clk);
      prog_lvl = 0; chip_sel = 0; din = 8'hFF;
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      sb.push_back('{due: cyc, drv: 1'b0, data: 8'h00, par: 1'b0, req: "R2"});
      @(negedge clk);

      read_arr(10'h005, "R5");                       // blank byte reads FF
      read_arr(10'h3FF, "R5");
      program_byte(10'h005, 8'hA5);
      read_arr(10'h005, "R3");
      program_byte(10'h005, 8'h5A);
      read_arr(10'h005, "R5");                       // A5 & 5A = 00
      program_byte(10'h123, 8'h3C);
      program_byte(10'h123, 8'hFF);                  // ones cannot return
      read_arr(10'h123, "R5");

      settle(1, 0, 0, 0, 10'h123, 1'b0, 8'h00, 0, "R1");   // output off
      settle(0, 1, 0, 0, 10'h123, 1'b0, 8'h00, 0, "R2");   // standby with gate open
      settle(0, 0, 0, 0, 10'h005, 1'b0, 8'h00, 0, "R2");

      // Program inhibit: level present, select low, zero data for several edges.
      din = 8'h00;
      settle(0, 1, 1, 0, 10'h007, 1'b0, 8'h00, 0, "R4");
      din = 8'hFF;
      read_arr(10'h007, "R4");
      settle(1, 1, 1, 0, 10'h008, 1'b0, 8'h00, 0, "R1");   // program mode never drives
      model[10'h008] = 8'hFF & din;
      read_arr(10'h008, "R3");

      settle(1, 1, 0, 1, 10'h002, 1'b1, 8'h1C, 1, "R6");
      settle(1, 1, 0, 1, 10'h3FE, 1'b1, 8'h1C, 1, "R6");
      settle(1, 1, 0, 1, 10'h3FF, 1'b1, 8'h83, 1, "R6");
      settle(1, 1, 0, 1, 10'h3FC, 1'b1, 8'h7F, 1, "R7");
      settle(1, 1, 0, 1, 10'h001, 1'b1, 8'h7F, 1, "R7");
      read_arr(10'h001, "R9");                       // identifier flag drop restarts latency

      chip_sel = 0; out_en = 0;
      repeat (4) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule